// File: doc/BRIEF.md
# Open-Drain Line Repeater with Master Arbitration

The block joins two half-duplex, single-wire data lines, one facing the host controller and one facing the card. Both lines idle HIGH through passive pull-ups, and the block leaves them alone until one of them falls. The first side to show a falling edge becomes master. After a fixed delay, the block turns on the pull-down of the other side (the slave) to copy the LOW. When the master line rises again, the block releases the slave pull-down and drives a short active pull-up pulse onto the slave line. The pulse lasts the same delay and gives a fast LOW-to-HIGH transition. The block then waits until both lines read HIGH and returns to idle.

The lines are modelled digitally. Each side has a sampled input, an active-low pull-down enable and an active pull-up enable. One counter on the system clock sets both the repeat delay and the pull-up width. A session enable input keeps both sides undriven outside a session. A reader front end uses three instances: one for the data line and one for each of the two auxiliary lines.

Top module: `od_line_repeater`

## Requirements
- R1: While reset is applied and in the first cycle after it, both pull-down enables are HIGH (inactive) and both pull-up enables are LOW.
- R2: With the session enable HIGH and the host line falling first, the card pull-down enable goes LOW at the (DELAY_CYC+1)th rising edge after the edge that first captures the host LOW. The host side is never driven during that transaction, and at most one pull-down enable is LOW at any time.
- R3: With the card line falling first, the host pull-down enable goes LOW with the same timing as in R2, and the card side is never driven.
- R4: While a transaction runs, the slave's own input is ignored. A LOW held on the slave line from outside does not change mastership, and the former master is never driven.
- R5: The slave pull-down releases at the first rising edge after the edge that captures the master HIGH. At that same edge the slave pull-up enable goes HIGH, and it stays HIGH for exactly DELAY_CYC cycles. A side never has its pull-up and pull-down enabled together.
- R6: After the pull-up pulse, the block stays busy until both sampled lines read HIGH. A fall on either line during that wait is not repeated. Once both lines are HIGH, a new fall is repeated with normal timing.
- R7: If both lines fall in the same clock cycle, the host side becomes master. Only the card pull-down is driven.
- R8: While the session enable is LOW, no pull-down or pull-up is enabled and falls are not repeated. Dropping the enable during a transaction releases all drive within the same cycle.
- R9: With DELAY_CYC=4 and a 50-cycle toggle period (25 LOW, 25 HIGH), every LOW phase of the master is repeated. Each one holds the slave pull-down for 25-DELAY_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| session_en | input | 1 | HIGH while a card session is active |
| host_line_i | input | 1 | Level seen on the host-side line |
| card_line_i | input | 1 | Level seen on the card-side line |
| host_pd_n_o | output | 1 | Host-side pull-down enable, active LOW |
| host_pu_o | output | 1 | Host-side active pull-up enable |
| card_pd_n_o | output | 1 | Card-side pull-down enable, active LOW |
| card_pu_o | output | 1 | Card-side active pull-up enable |

## Verification
Arbitration is the one place where both sides' functions land in the same cycle: a host fall and a card fall can both be captured by the same clock edge. The bench provokes this by pulling both modelled lines LOW at the same falling clock edge. It judges the result by requiring the card pull-down at the exact repeat cycle, no host drive at any point, and a pull-up pulse on the card side only. A related overlap occurs when the enable drops in the same cycle that the repeat is active. The bench checks that case one nanosecond after the change.

// File: rtl/odr_pkg.sv
package odr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DRIVE,
    ST_PULSE,
    ST_SETTLE
  } odr_state_e;

  localparam logic SIDE_HOST = 1'b0;
  localparam logic SIDE_CARD = 1'b1;

  // Counter width needed to hold DELAY-1
  function automatic int unsigned odr_cnt_w(input int unsigned delay);
    return (delay > 1) ? $clog2(delay) : 1;
  endfunction

  // Arbitration: host wins a tie
  function automatic logic odr_pick(input logic host_fall, input logic card_fall);
    return (card_fall && !host_fall) ? SIDE_CARD : SIDE_HOST;
  endfunction

  // Cycles the slave pull-down stays on for a master LOW of low_len cycles
  function automatic int odr_hold_cycles(input int low_len, input int delay);
    return (low_len > delay) ? (low_len - delay) : 0;
  endfunction

endpackage

// File: rtl/odr_line_sampler.sv
module odr_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  logic smp_q;
  logic prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b1;
      prv_q <= 1'b1;
    end else begin
      smp_q <= line_i;
      prv_q <= smp_q;
    end
  end

  assign level_o = smp_q;
  assign fall_o  = prv_q & ~smp_q;
endmodule

// File: rtl/odr_delay_timer.sv
module odr_delay_timer #(
  parameter int unsigned DELAY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned CW = odr_pkg::odr_cnt_w(DELAY_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater
  import odr_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic session_en,
  input  logic host_line_i,
  input  logic card_line_i,
  output logic host_pd_n_o,
  output logic host_pu_o,
  output logic card_pd_n_o,
  output logic card_pu_o
);
  odr_state_e st_q, st_d;
  logic       mst_q, mst_d;
  logic       tmr_load, tmr_done;
  logic [1:0] line_in, side_lvl, side_fall, pd_act, pu_act;

  // named events for the checker
  logic idle_w, settle_w, master_lvl, evt_take, evt_release;

  assign line_in = {card_line_i, host_line_i};

  for (genvar g = 0; g < 2; g++) begin : g_side
    odr_line_sampler u_smp (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line_in[g]),
      .level_o (side_lvl[g]),
      .fall_o  (side_fall[g])
    );
    assign pd_act[g] = session_en & (st_q == ST_DRIVE) & (mst_q != 1'(g));
    assign pu_act[g] = session_en & (st_q == ST_PULSE) & (mst_q != 1'(g));
  end

  odr_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .done_o (tmr_done)
  );

  assign idle_w      = (st_q == ST_IDLE);
  assign settle_w    = (st_q == ST_SETTLE);
  assign master_lvl  = side_lvl[mst_q];
  assign evt_take    = session_en & idle_w & (|side_fall);
  assign evt_release = session_en & (st_q == ST_DRIVE) & master_lvl;

  always_comb begin
    st_d     = st_q;
    mst_d    = mst_q;
    tmr_load = 1'b0;
    if (!session_en) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (evt_take) begin
          st_d     = ST_WAIT;
          mst_d    = odr_pick(side_fall[0], side_fall[1]);
          tmr_load = 1'b1;
        end
        ST_WAIT:   if (tmr_done) st_d = ST_DRIVE;
        ST_DRIVE: if (evt_release) begin
          st_d     = ST_PULSE;
          tmr_load = 1'b1;
        end
        ST_PULSE:  if (tmr_done) st_d = ST_SETTLE;
        ST_SETTLE: if (&side_lvl) st_d = ST_IDLE;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      mst_q <= SIDE_HOST;
    end else begin
      st_q  <= st_d;
      mst_q <= mst_d;
    end
  end

  assign host_pd_n_o = ~pd_act[0];
  assign card_pd_n_o = ~pd_act[1];
  assign host_pu_o   = pu_act[0];
  assign card_pu_o   = pu_act[1];
endmodule

// File: rtl/odr_checker.sv
module odr_checker #(
  parameter int unsigned DELAY_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic session_en,
  input logic host_pd_n,
  input logic host_pu,
  input logic card_pd_n,
  input logic card_pu,
  input logic host_fall,
  input logic card_fall,
  input logic host_lvl,
  input logic card_lvl,
  input logic idle_w,
  input logic settle_w,
  input logic mst_q
);
  int unsigned pu_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pu_run <= 0;
    else if (host_pu || card_pu) pu_run <= pu_run + 1;
    else                       pu_run <= 0;
  end

  p_one_pulldown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!host_pd_n && !card_pd_n));

  p_no_pd_with_pu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!host_pd_n && host_pu) && !(!card_pd_n && card_pu));

  p_host_pu_after_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_pu) |-> $past(!host_pd_n));

  p_card_pu_after_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_pu) |-> $past(!card_pd_n));

  p_pu_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pu || card_pu) |-> (pu_run < DELAY_CYC));

  p_quiet_off_session_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !session_en |-> (host_pd_n && card_pd_n && !host_pu && !card_pu));

  p_master_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_w && $past(!idle_w)) |-> $stable(mst_q));

  p_tie_to_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && session_en && host_fall && card_fall) |=> (mst_q == 1'b0));

  p_settle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_w && !(host_lvl && card_lvl)) |=> !idle_w);
endmodule

bind od_line_repeater odr_checker #(.DELAY_CYC(DELAY_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .session_en (session_en),
  .host_pd_n  (host_pd_n_o),
  .host_pu    (host_pu_o),
  .card_pd_n  (card_pd_n_o),
  .card_pu    (card_pu_o),
  .host_fall  (side_fall[0]),
  .card_fall  (side_fall[1]),
  .host_lvl   (side_lvl[0]),
  .card_lvl   (side_lvl[1]),
  .idle_w     (idle_w),
  .settle_w   (settle_w),
  .mst_q      (mst_q)
);

// File: tb/tb_od_line_repeater.sv
module tb_od_line_repeater;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic session_en = 1'b1;
  logic host_ext = 1'b0;   // external agent pulling host line LOW
  logic card_ext = 1'b0;   // external agent pulling card line LOW
  logic host_pd_n, host_pu, card_pd_n, card_pu;
  logic host_line, card_line;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  // wired-AND line model: any pull-down wins over the pull-ups
  assign host_line = !(host_ext || !host_pd_n);
  assign card_line = !(card_ext || !card_pd_n);

  od_line_repeater #(.DELAY_CYC(D)) dut (
    .clk(clk), .rst_n(rst_n), .session_en(session_en),
    .host_line_i(host_line), .card_line_i(card_line),
    .host_pd_n_o(host_pd_n), .host_pu_o(host_pu),
    .card_pd_n_o(card_pd_n), .card_pu_o(card_pu)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One LOW pulse of low_len cycles from one side; records slave activity.
  task automatic pulse_watch(input bit from_card, input int low_len, input int span,
                             output int pd_first, output int pd_cnt,
                             output int pu_first, output int pu_cnt, output int mst_drv);
    pd_first = -1; pd_cnt = 0; pu_first = -1; pu_cnt = 0; mst_drv = 0;
    if (from_card) card_ext = 1'b1; else host_ext = 1'b1;
    for (int j = 1; j <= span; j++) begin
      @(negedge clk);
      if (from_card ? !host_pd_n : !card_pd_n) begin
        pd_cnt++; if (pd_first < 0) pd_first = j;
      end
      if (from_card ? host_pu : card_pu) begin
        pu_cnt++; if (pu_first < 0) pu_first = j;
      end
      if (from_card ? (!card_pd_n || card_pu) : (!host_pd_n || host_pu)) mst_drv++;
      if (j == low_len) begin
        if (from_card) card_ext = 1'b0; else host_ext = 1'b0;
      end
    end
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R1", "host_pd_n in reset", host_pd_n, 1);
    chk("R1", "card_pd_n in reset", card_pd_n, 1);
    chk("R1", "pull-ups in reset", host_pu | card_pu, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", "drive after reset", {host_pd_n, card_pd_n, host_pu, card_pu}, 4'b1100);
    cyc(3);
  endtask

  task automatic t_host_first;
    int pf, pc, uf, uc, md;
    pulse_watch(1'b0, 12, 12 + D + 8, pf, pc, uf, uc, md);
    chk("R2", "card pull-down onset", pf, D + 2);
    chk("R2", "card pull-down cycles", pc, odr_pkg::odr_hold_cycles(12, D));
    chk("R2", "host side driven", md, 0);
    chk("R5", "card pull-up onset", uf, 12 + 2);
    chk("R5", "card pull-up width", uc, D);
  endtask

  task automatic t_card_first;
    int pf, pc, uf, uc, md;
    pulse_watch(1'b1, 10, 10 + D + 8, pf, pc, uf, uc, md);
    chk("R3", "host pull-down onset", pf, D + 2);
    chk("R3", "host pull-down cycles", pc, 10 - D);
    chk("R3", "card side driven", md, 0);
    chk("R5", "host pull-up width", uc, D);
  endtask

  task automatic t_slave_ignored;
    int host_drv = 0, card_pd = 0, pf, pc, uf, uc, md;
    host_ext = 1'b1;
    for (int j = 1; j <= 12 + D + 10; j++) begin
      @(negedge clk);
      if (!host_pd_n || host_pu) host_drv++;
      if (!card_pd_n) card_pd++;
      if (j == D + 4) card_ext = 1'b1;
      if (j == 12) host_ext = 1'b0;
      if (j == 12 + D + 4) card_ext = 1'b0;
    end
    chk("R4", "old master driven", host_drv, 0);
    chk("R4", "card pull-down cycles", card_pd, 12 - D);
    cyc(4);
    pulse_watch(1'b1, 10, 10 + D + 8, pf, pc, uf, uc, md);
    chk("R4", "next card-first onset", pf, D + 2);
  endtask

  task automatic t_settle_wait;
    int late_drv = 0, pf, pc, uf, uc, md;
    host_ext = 1'b1;
    for (int j = 1; j <= 10 + D + 16; j++) begin
      @(negedge clk);
      if (j > 10 + D + 2 && (!host_pd_n || !card_pd_n || host_pu || card_pu)) late_drv++;
      if (j == 9) card_ext = 1'b1;
      if (j == 10) host_ext = 1'b0;
      if (j == 10 + D + 3) host_ext = 1'b1;
      if (j == 10 + D + 8) card_ext = 1'b0;
      if (j == 10 + D + 11) host_ext = 1'b0;
    end
    chk("R6", "drive during settle", late_drv, 0);
    pulse_watch(1'b0, 12, 12 + D + 8, pf, pc, uf, uc, md);
    chk("R6", "repeat after settle onset", pf, D + 2);
    chk("R6", "repeat after settle cycles", pc, 12 - D);
  endtask

  task automatic t_tie;
    int card_pd_first = -1, host_drv = 0, card_pu_cnt = 0;
    host_ext = 1'b1; card_ext = 1'b1;
    for (int j = 1; j <= 10 + D + 8; j++) begin
      @(negedge clk);
      if (!card_pd_n && card_pd_first < 0) card_pd_first = j;
      if (!host_pd_n || host_pu) host_drv++;
      if (card_pu) card_pu_cnt++;
      if (j == 10) begin host_ext = 1'b0; card_ext = 1'b0; end
    end
    chk("R7", "card pull-down onset on tie", card_pd_first, D + 2);
    chk("R7", "host driven on tie", host_drv, 0);
    chk("R7", "card pull-up width on tie", card_pu_cnt, D);
  endtask

  task automatic t_disable;
    int drv = 0, pf, pc, uf, uc, md;
    session_en = 1'b0;
    host_ext = 1'b1;
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      if (!host_pd_n || !card_pd_n || host_pu || card_pu) drv++;
      if (j == 12) host_ext = 1'b0;
      if (j == 15) card_ext = 1'b1;
      if (j == 25) card_ext = 1'b0;
    end
    chk("R8", "drive while disabled", drv, 0);
    session_en = 1'b1;
    cyc(3);
    host_ext = 1'b1;
    cyc(D + 3);
    chk("R8", "repeat active before drop", card_pd_n, 0);
    session_en = 1'b0;
    #1;
    chk("R8", "card pull-down after drop", card_pd_n, 1);
    chk("R8", "pull-ups after drop", host_pu | card_pu, 0);
    cyc(2);
    host_ext = 1'b0;
    cyc(3);
    session_en = 1'b1;
    cyc(3);
    pulse_watch(1'b0, 12, 12 + D + 8, pf, pc, uf, uc, md);
    chk("R8", "repeat after re-enable", pc, 12 - D);
  endtask

  task automatic t_rate;
    int onsets = 0, pd_total = 0;
    logic prev_pd_n = 1'b1;
    for (int p = 0; p < 5; p++) begin
      host_ext = 1'b1;
      for (int j = 1; j <= 50; j++) begin
        @(negedge clk);
        if (!card_pd_n) pd_total++;
        if (prev_pd_n && !card_pd_n) onsets++;
        prev_pd_n = card_pd_n;
        if (j == 25) host_ext = 1'b0;
      end
    end
    chk("R9", "repeated LOW phases", onsets, 5);
    chk("R9", "total pull-down cycles", pd_total, 5 * odr_pkg::odr_hold_cycles(25, D));
  endtask

  initial begin
    t_reset;
    t_host_first;
    cyc(3);
    t_card_first;
    cyc(3);
    t_slave_ignored;
    cyc(3);
    t_settle_wait;
    cyc(3);
    t_tie;
    cyc(3);
    t_disable;
    cyc(3);
    t_rate;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule